// File: doc/BRIEF.md
# Two-Stage Decimation Filter

This block takes a stream of paired left/right audio samples that arrive at four or two times the final sample rate and produces filtered left/right samples at the final rate. Two decimate-by-two FIR stages sit in cascade: a short 21-tap stage followed by a long 141-tap stage. Each stage has one time-shared multiply-accumulate engine, with one lane per channel. Because the taps are symmetric, the two samples that share a coefficient are added before the multiply. A stage therefore needs only about half as many multiply steps as it has taps.

A mode input chooses the path. With the mode high, the input is treated as 4fs and passes through both stages. With the mode low, the input is treated as 2fs and goes straight to the long stage, and the short stage stays idle. The coefficients come from a fixed triangular weight function inside the RTL. Each stage rounds and saturates its result to a 20-bit two's-complement word.

Top module: `decim_cascade`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and both output words are 0 until the first result is produced. Every sample history is cleared to zero by reset.
- R2: When `quarter_mode` is 1, every accepted input pair enters the 21-tap stage. Each of its results feeds the 141-tap stage. One output pair is produced after the 4th, 8th, 12th, … accepted input after reset.
- R3: When `quarter_mode` is 0, every accepted input pair goes directly to the 141-tap stage, and the 21-tap stage produces nothing. One output pair is produced after the 2nd, 4th, … accepted input. The mode is changed only while reset is held.
- R4: Each stage result is computed as follows. y = sum over k of h[k]·x[n−k], summed over all taps, with zero history before reset release. This sum is divided by 2^S, with rounding of exact halves toward +infinity, and then saturated to 20 bits. The shift S is 6 for the 21-tap stage and 12 for the 141-tap stage.
- R5: The coefficients are h[k] = min(k, N−1−k) + 1 for an N-tap stage, which makes them symmetric. In mode 0, an impulse gives output j and output 69−j with equal values.
- R6: Inputs are 18-bit two's complement. Each input is placed in the 20-bit working word shifted left by 2. `in_valid` pulses are at least 72 clock cycles apart.
- R7: `out_valid` is a single-cycle pulse for each output pair. Both output words are valid in that cycle.
- R8: The left and right lanes are filtered independently. Different patterns on the two inputs give each lane the result of its own pattern only.
- R9: A result above 524287 or below −524288 is clamped to that limit in the 20-bit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quarter_mode | input | 1 | 1: two stages (4fs in), 0: long stage only (2fs in) |
| in_valid | input | 1 | One-cycle strobe for an input pair |
| in_l | input | 18 | Left input sample, two's complement |
| in_r | input | 18 | Right input sample, two's complement |
| out_valid | output | 1 | One-cycle strobe for an output pair |
| out_l | output | 20 | Left output sample, two's complement |
| out_r | output | 20 | Right output sample, two's complement |

## Verification
An impulse in half mode traces out the whole 141-tap response. A pre-add that paired the wrong buffer slots, or a coefficient off by one step, would break the mirror symmetry of the outputs and differ from the reference convolution. Long DC runs in quarter mode test two things: that the output cadence is one result per four inputs, and that the 21-tap results are handed correctly to the long stage. A decimation phase error would change the output count or shift the transient. Full-scale positive and negative inputs check the clamp at both rails; a wrapped sum would flip sign. Unrelated patterns on the two lanes expose any crosstalk between them.

// File: rtl/decim_half_stage.sv
module decim_half_stage #(
  parameter int TAPS  = 21,
  parameter int SHIFT = 6,
  parameter int W     = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_l,
  input  logic signed [W-1:0] in_r,
  output logic                out_valid,
  output logic signed [W-1:0] out_l,
  output logic signed [W-1:0] out_r
);
  localparam int HALF  = (TAPS - 1) / 2;
  localparam int PW    = $clog2(TAPS);
  localparam int SW    = $clog2(HALF + 1);
  localparam int ACC_W = W + 1 + 2 * $clog2(TAPS + 1);
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(64'sd1 <<< (SHIFT - 1));
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-(64'sd1 <<< (W - 1)));

  logic signed [W-1:0] hist_l [TAPS];
  logic signed [W-1:0] hist_r [TAPS];
  logic [PW-1:0] head, base;
  logic [SW-1:0] step;
  logic phase, run;
  logic signed [ACC_W-1:0] acc_l, acc_r;

  wire [PW:0] base_x = {1'b0, base};
  wire [PW:0] step_x = (PW+1)'(step);
  wire [PW:0] mirr_x = (PW+1)'(TAPS - 1) - step_x;
  wire [PW:0] ia = (base_x >= step_x) ? base_x - step_x : base_x + (PW+1)'(TAPS) - step_x;
  wire [PW:0] ib = (base_x >= mirr_x) ? base_x - mirr_x : base_x + (PW+1)'(TAPS) - mirr_x;
  wire        last = (step == SW'(HALF));

  function automatic logic signed [ACC_W-1:0] term(input logic signed [W-1:0] a,
                                                   input logic signed [W-1:0] b,
                                                   input logic mid,
                                                   input logic [SW-1:0] k);
    logic signed [W:0] p;
    logic signed [ACC_W-1:0] w;
    p = mid ? (W+1)'(a) : (W+1)'(a) + (W+1)'(b);
    w = ACC_W'($signed({1'b0, k})) + ACC_W'(1);
    return ACC_W'(p) * w;
  endfunction

  function automatic logic signed [W-1:0] clamp(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] r;
    r = (a + RND) >>> SHIFT;
    if (r > MAXV) r = MAXV;
    else if (r < MINV) r = MINV;
    return W'(r);
  endfunction

  wire signed [ACC_W-1:0] nx_l = acc_l + term(hist_l[ia[PW-1:0]], hist_l[ib[PW-1:0]], last, step);
  wire signed [ACC_W-1:0] nx_r = acc_r + term(hist_r[ia[PW-1:0]], hist_r[ib[PW-1:0]], last, step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) begin
        hist_l[i] <= '0;
        hist_r[i] <= '0;
      end
      head <= '0; base <= '0; step <= '0;
      phase <= 1'b0; run <= 1'b0;
      acc_l <= '0; acc_r <= '0;
      out_valid <= 1'b0; out_l <= '0; out_r <= '0;
    end else begin
      out_valid <= 1'b0;
      if (run) begin
        acc_l <= nx_l;
        acc_r <= nx_r;
        step  <= step + 1'b1;
        if (last) begin
          run       <= 1'b0;
          out_valid <= 1'b1;
          out_l     <= clamp(nx_l);
          out_r     <= clamp(nx_r);
        end
      end
      if (in_valid) begin
        hist_l[head] <= in_l;
        hist_r[head] <= in_r;
        base  <= head;
        head  <= (head == PW'(TAPS - 1)) ? '0 : head + 1'b1;
        phase <= ~phase;
        if (phase) begin
          run   <= 1'b1;
          step  <= '0;
          acc_l <= '0;
          acc_r <= '0;
        end
      end
    end
  end

  a_r6_input_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !run);
  a_r7_single_cycle_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r5_pair_starts_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(in_valid) && $past(phase)));
endmodule

// File: rtl/decim_cascade.sv
module decim_cascade #(
  parameter int IN_W    = 18,
  parameter int OUT_W   = 20,
  parameter int TAPS_A  = 21,
  parameter int TAPS_B  = 141,
  parameter int SHIFT_A = 6,
  parameter int SHIFT_B = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    quarter_mode,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_l,
  input  logic signed [IN_W-1:0]  in_r,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_l,
  output logic signed [OUT_W-1:0] out_r
);
  localparam int ALIGN = OUT_W - IN_W;

  wire signed [OUT_W-1:0] x_l = OUT_W'(in_l) <<< ALIGN;
  wire signed [OUT_W-1:0] x_r = OUT_W'(in_r) <<< ALIGN;

  logic                    a_valid;
  logic signed [OUT_W-1:0] a_l, a_r;

  decim_half_stage #(.TAPS(TAPS_A), .SHIFT(SHIFT_A), .W(OUT_W)) u_short (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid & quarter_mode),
    .in_l(x_l), .in_r(x_r),
    .out_valid(a_valid), .out_l(a_l), .out_r(a_r));

  wire                    b_in_valid = quarter_mode ? a_valid : in_valid;
  wire signed [OUT_W-1:0] b_in_l     = quarter_mode ? a_l : x_l;
  wire signed [OUT_W-1:0] b_in_r     = quarter_mode ? a_r : x_r;

  decim_half_stage #(.TAPS(TAPS_B), .SHIFT(SHIFT_B), .W(OUT_W)) u_long (
    .clk(clk), .rst_n(rst_n), .in_valid(b_in_valid),
    .in_l(b_in_l), .in_r(b_in_r),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r));

  a_r3_short_idle_in_half_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !quarter_mode |-> !a_valid);
endmodule

// File: tb/decim_cascade_test.sv
module decim_cascade_test;
  localparam int GAP = 80;
  localparam int MAXO = 256;

  logic clk = 0, rst_n = 0, quarter_mode = 0, in_valid = 0;
  logic signed [17:0] in_l = '0, in_r = '0;
  logic out_valid;
  logic signed [19:0] out_l, out_r;

  always #10 clk = ~clk;

  decim_cascade uut (.clk(clk), .rst_n(rst_n), .quarter_mode(quarter_mode),
    .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r));

  int n_cmp = 0, n_bad = 0;
  longint h1 [21];
  longint h2 [141];
  longint hs1 [2][21];
  longint hs2 [2][141];
  int cnt1, cnt2, n_exp, n_got;
  longint exp_l [MAXO], exp_r [MAXO], got_l [MAXO], got_r [MAXO];
  logic prev_valid = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic longint rsat(input longint acc, input int sh);
    longint r;
    r = (acc + (64'sd1 <<< (sh - 1))) >>> sh;
    if (r > 524287) r = 524287;
    if (r < -524288) r = -524288;
    return r;
  endfunction

  task automatic push_long(input longint xl, input longint xr);
    longint s [2];
    for (int c = 0; c < 2; c++) begin
      for (int k = 140; k > 0; k--) hs2[c][k] = hs2[c][k-1];
      hs2[c][0] = (c == 0) ? xl : xr;
    end
    cnt2++;
    if (cnt2 % 2 == 0) begin
      for (int c = 0; c < 2; c++) begin
        s[c] = 0;
        for (int k = 0; k < 141; k++) s[c] += h2[k] * hs2[c][k];
      end
      exp_l[n_exp] = rsat(s[0], 12);
      exp_r[n_exp] = rsat(s[1], 12);
      n_exp++;
    end
  endtask

  task automatic model_in(input int l, input int r);
    longint s [2];
    if (quarter_mode) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 20; k > 0; k--) hs1[c][k] = hs1[c][k-1];
        hs1[c][0] = (c == 0) ? longint'(l) * 4 : longint'(r) * 4;
      end
      cnt1++;
      if (cnt1 % 2 == 0) begin
        for (int c = 0; c < 2; c++) begin
          s[c] = 0;
          for (int k = 0; k < 21; k++) s[c] += h1[k] * hs1[c][k];
        end
        push_long(rsat(s[0], 6), rsat(s[1], 6));
      end
    end else begin
      push_long(longint'(l) * 4, longint'(r) * 4);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 0;
    quarter_mode = mode;
    in_valid = 0;
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 21; k++) hs1[c][k] = 0;
      for (int k = 0; k < 141; k++) hs2[c][k] = 0;
    end
    cnt1 = 0; cnt2 = 0; n_exp = 0; n_got = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_l == 0 && out_r == 0, "R1 in reset", out_l, 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && out_l == 0 && out_r == 0, "R1 after release", out_r, 0);
  endtask

  task automatic send(input int l, input int r);
    in_l = 18'(l); in_r = 18'(r); in_valid = 1;
    model_in(l, r);
    @(negedge clk);
    in_valid = 0;
    repeat (GAP - 1) @(negedge clk);
  endtask

  task automatic compare_all(input string tag);
    repeat (200) @(negedge clk);
    check(n_got == n_exp, tag, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(got_l[i] == exp_l[i], "R4 left lane", got_l[i], exp_l[i]);
      check(got_r[i] == exp_r[i], "R8 right lane", got_r[i], exp_r[i]);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (prev_valid) check(0, "R7 pulse width", 2, 1);
      if (n_got < MAXO) begin
        got_l[n_got] = longint'(out_l);
        got_r[n_got] = longint'(out_r);
      end
      n_got++;
    end
    prev_valid = rst_n && out_valid;
  end

  task automatic t_impulse_half;
    do_reset(0);
    send(1000, 0);
    send(0, -500);
    for (int i = 0; i < 146; i++) send(0, 0);
    compare_all("R3 output count half mode");
    for (int j = 0; j < 35; j++)
      check(got_l[j] == got_l[69 - j], "R5 symmetric response", got_l[j], got_l[69 - j]);
  endtask

  task automatic t_dc_quarter;
    do_reset(1);
    for (int i = 0; i < 300; i++) send(20000, -7777);
    compare_all("R2 output count quarter mode");
  endtask

  task automatic t_lanes_quarter;
    do_reset(1);
    for (int i = 0; i < 120; i++) send(((i % 3) == 0) ? -40000 : 35000, i * 900 - 50000);
    compare_all("R8 lane count");
  endtask

  task automatic t_saturate;
    do_reset(0);
    for (int i = 0; i < 150; i++) send(131071, -131072);
    compare_all("R9 count");
    check(got_l[n_got - 1] == 524287, "R9 positive clamp", got_l[n_got - 1], 524287);
    check(got_r[n_got - 1] == -524288, "R9 negative clamp", got_r[n_got - 1], -524288);
    check(n_exp == 75, "R3 R6 half-mode cadence", n_exp, 75);
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    for (int k = 0; k < 21; k++) h1[k] = ((k < 20 - k) ? k : 20 - k) + 1;
    for (int k = 0; k < 141; k++) h2[k] = ((k < 140 - k) ? k : 140 - k) + 1;
    t_impulse_half();
    t_dc_quarter();
    t_lanes_quarter();
    t_saturate();
    finish_up();
  end
endmodule